// File: doc/BRIEF.md
# Predicated Set-First Mask Generator

This block turns a source bitmask into one of three masks that are built around the lowest set source bit. The three masks are: every position before that bit, every position up to and including it, or that single position alone. A 2-bit mode selects which mask is produced. A vector unit uses the block to build loop-exit and first-hit masks, for example to stop a loop just before the first matching element or to pick out that element.

An optional predicate mask limits the work to active positions. When the predicate is in use, each maximal run of consecutive active bits is a search of its own: the search starts again at the first active bit after any masked-out stretch. Masked-out positions pass the previous destination value through unchanged, so the result never contains undefined bits. The per-position search is a prefix recurrence. A parameter builds it either as a serial chain or as a logarithmic-depth prefix tree. The result is registered once, which gives one cycle of latency.

Top module: `setfirst_mask_unit`

## Requirements
- R1: `dest_mask` is a register that loads the newly computed mask on every rising clock edge, so a result appears one cycle after its inputs are applied. An asynchronous active-low reset clears it to all zeros.
- R2: Mode 0 (before-first) writes 1 at each active position below the lowest set source bit of its segment, and 0 at that position and at every later active position of the segment. Unpredicated, source 10010100 gives 00000011 and source 10010101 gives 00000000.
- R3: In mode 0, a segment with no set source bit has all of its active positions written 1. Unpredicated, source 0 gives all ones.
- R4: Mode 1 (including-first) behaves like mode 0 but also writes 1 at the position of the first set source bit. Unpredicated, source 10010100 gives 00000111.
- R5: Mode 2 (only-first) writes 1 only at the first set source bit of each segment and 0 at every other active position. Unpredicated, source 10010100 gives 00000100, and source 0 gives 0.
- R6: With `pred_en` = 0 every position is active, `pred_mask` is ignored, and the whole vector is one segment that starts at bit 0.
- R7: With `pred_en` = 1, position i is active exactly when `pred_mask[i]` = 1. Each maximal run of active positions is a separate segment, and the search restarts at its lowest bit. With predicate 11000011, mode 0 on source 10010100 gives 01000011, and mode 2 on source 11010100 gives 01000000.
- R8: With `pred_en` = 1, every masked-out position i of the result equals `prev_mask[i]`.
- R9: Mode 3 is reserved. It loads `prev_mask` unchanged into the result in every position.
- R10: Parameter `SCAN_STYLE` selects a serial chain (0) or a logarithmic-depth prefix tree (1). Both give identical results for every input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| src_mask | input | WIDTH | Source bitmask that is searched for its first set bit per segment |
| pred_mask | input | WIDTH | Predicate; 1 marks an active position |
| pred_en | input | 1 | 1 applies `pred_mask`; 0 makes every position active |
| mode | input | 2 | 0 before-first, 1 including-first, 2 only-first, 3 hold previous |
| prev_mask | input | WIDTH | Previous destination value, passed through at masked-out positions |
| dest_mask | output | WIDTH | Registered result mask |

## Verification
The bench builds two 6-bit instances, one with the serial chain and one with the prefix tree. It sweeps every combination of source, predicate, enable and mode through both, 32768 vectors in all, against an arithmetic bit-serial model. At this width every possible arrangement of segments, empty segments and masked gaps is reached, and the two scan styles are compared on each vector. A third instance of width 8 with the prefix tree checks the worked patterns with predicate 11000011, and also checks the reset value and the one-cycle latency.

// File: rtl/setfirst_pkg.sv
package setfirst_pkg;

  // Mode encoding at the block edge.
  typedef enum logic [1:0] {
    SF_BEFORE  = 2'd0,
    SF_INCLUDE = 2'd1,
    SF_ONLY    = 2'd2,
    SF_HOLD    = 2'd3
  } sf_mode_e;

  // Scan implementation choices.
  localparam int SF_SCAN_SERIAL = 0;
  localparam int SF_SCAN_TREE   = 1;

endpackage

// File: rtl/setfirst_seg_scan.sv
// Inclusive generate/propagate prefix scan:
//   found_o[i] = gen_i[i] | prop_i[i] & found_o[i-1], found_o[-1] = 0.
// A zero propagate bit ends a segment (kills what came from below).
module setfirst_seg_scan #(
  parameter int WIDTH      = 64,
  parameter int SCAN_STYLE = setfirst_pkg::SF_SCAN_TREE
) (
  input  logic [WIDTH-1:0] gen_i,
  input  logic [WIDTH-1:0] prop_i,
  output logic [WIDTH-1:0] found_o
);

  localparam int LVLS = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  generate
    if (SCAN_STYLE == setfirst_pkg::SF_SCAN_SERIAL) begin : g_serial
      // One AND-OR stage per bit: depth grows with WIDTH.
      always_comb begin
        logic acc;
        acc = 1'b0;
        for (int i = 0; i < WIDTH; i++) begin
          acc        = gen_i[i] | (prop_i[i] & acc);
          found_o[i] = acc;
        end
      end
    end else begin : g_tree
      // Log-depth prefix tree, distance doubles per level.
      logic [WIDTH-1:0] g_lvl [0:LVLS];
      logic [WIDTH-1:0] p_lvl [0:LVLS-1];

      assign g_lvl[0] = gen_i;
      assign p_lvl[0] = prop_i;

      for (genvar k = 0; k < LVLS; k++) begin : g_level
        localparam int DIST = 1 << k;
        // Group generate: own group, or lower group passed through own.
        assign g_lvl[k+1] = g_lvl[k] | (p_lvl[k] & (g_lvl[k] << DIST));
        if (k + 1 < LVLS) begin : g_prop
          // Positions below DIST have no lower group: keep their propagate.
          localparam logic [WIDTH-1:0] LOWKEEP = {{(WIDTH-DIST){1'b0}}, {DIST{1'b1}}};
          assign p_lvl[k+1] = p_lvl[k] & ((p_lvl[k] << DIST) | LOWKEEP);
        end
      end

      assign found_o = g_lvl[LVLS];
    end
  endgenerate

endmodule

// File: rtl/setfirst_mode_mux.sv
// Per-position result select. found_below[i] says a set source bit
// already occurred earlier in the same segment.
module setfirst_mode_mux
  import setfirst_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  sf_mode_e         mode_i,
  input  logic [WIDTH-1:0] src_i,
  input  logic [WIDTH-1:0] act_i,
  input  logic [WIDTH-1:0] found_below_i,
  input  logic [WIDTH-1:0] prev_i,
  output logic [WIDTH-1:0] dest_o
);

  logic [WIDTH-1:0] searching;
  logic [WIDTH-1:0] active_val;
  logic             hold_all;

  assign searching = ~found_below_i;

  always_comb begin
    hold_all   = 1'b0;
    active_val = '0;
    unique case (mode_i)
      SF_BEFORE:  active_val = searching & ~src_i;
      SF_INCLUDE: active_val = searching;
      SF_ONLY:    active_val = searching & src_i;
      default:    hold_all   = 1'b1;
    endcase
  end

  always_comb begin
    if (hold_all) begin
      dest_o = prev_i;
    end else begin
      dest_o = (active_val & act_i) | (prev_i & ~act_i);
    end
  end

endmodule

// File: rtl/setfirst_mask_unit.sv
// Predicated set-first mask generator, one register stage.
// rst_n is asserted asynchronously; its release is expected to be
// synchronous to clk. WIDTH must be at least 2.
module setfirst_mask_unit
  import setfirst_pkg::*;
#(
  parameter int WIDTH      = 64,
  parameter int SCAN_STYLE = SF_SCAN_TREE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] src_mask,
  input  logic [WIDTH-1:0] pred_mask,
  input  logic             pred_en,
  input  logic [1:0]       mode,
  input  logic [WIDTH-1:0] prev_mask,
  output logic [WIDTH-1:0] dest_mask
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] act;
  logic [WIDTH-1:0] scan_gen;
  logic [WIDTH-1:0] scan_prop;
  logic [WIDTH-1:0] found_below;
  logic [WIDTH-1:0] dest_d;
  logic [WIDTH-1:0] dest_q;
  logic             load_en;

  // Active positions (R6, R7).
  assign act = pred_en ? pred_mask : '1;

  // Inputs shifted up by one so that the inclusive scan yields, at
  // position i, what was seen at positions strictly below i.
  assign scan_gen  = {act[WIDTH-2:0] & src_mask[WIDTH-2:0], 1'b0};
  assign scan_prop = {act[WIDTH-2:0], 1'b0};

  setfirst_seg_scan #(
    .WIDTH      (WIDTH),
    .SCAN_STYLE (SCAN_STYLE)
  ) u_scan (
    .gen_i   (scan_gen),
    .prop_i  (scan_prop),
    .found_o (found_below)
  );

  setfirst_mode_mux #(
    .WIDTH (WIDTH)
  ) u_mux (
    .mode_i        (sf_mode_e'(mode)),
    .src_i         (src_mask),
    .act_i         (act),
    .found_below_i (found_below),
    .prev_i        (prev_mask),
    .dest_o        (dest_d)
  );

  // Result register loads every cycle (R1).
  assign load_en = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dest_q <= '0;
    end else if (load_en) begin
      dest_q <= dest_d;
    end
  end

  assign dest_mask = dest_q;

  // ---------------------------------------------------------------
  // Assertions
  // ---------------------------------------------------------------
  // seen_q marks that the register has loaded once since reset.
  logic seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
    end else begin
      seen_q <= 1'b1;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_clear : assert (dest_mask == '0);
    end
  end

  a_r2_before_lowbits : assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(mode) == 2'd0 && !$past(pred_en) && $past(src_mask) != '0)
    |-> dest_mask == (($past(src_mask) & (~$past(src_mask) + ONE)) - ONE));

  a_r3_before_empty : assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(mode) == 2'd0 && $past(src_mask) == '0)
    |-> (dest_mask | ~($past(pred_en) ? $past(pred_mask) : '1)) == '1);

  a_r4_include_span : assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(mode) == 2'd1 && !$past(pred_en) && $past(src_mask) != '0)
    |-> dest_mask == ($past(src_mask) ^ ($past(src_mask) - ONE)));

  a_r5_only_lowest : assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(mode) == 2'd2 && !$past(pred_en))
    |-> dest_mask == ($past(src_mask) & (~$past(src_mask) + ONE)));

  a_r5_only_onehot : assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(mode) == 2'd2 && !$past(pred_en)) |-> $onehot0(dest_mask));

  a_r8_masked_keep : assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(pred_en))
    |-> ((dest_mask ^ $past(prev_mask)) & ~$past(pred_mask)) == '0);

  a_r9_hold_prev : assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(mode) == 2'd3) |-> dest_mask == $past(prev_mask));

endmodule

// File: tb/setfirst_mask_unit_bench.sv
`timescale 1ns/1ps
module setfirst_mask_unit_bench;

  logic clk;
  logic rst_n;
  int   checks;
  int   failures;

  // 6-bit tree and serial builds, 8-bit tree build.
  logic [5:0] s6, p6, v6, d6_tree, d6_ser;
  logic       e6;
  logic [1:0] m6;
  logic [7:0] s8, p8, v8, d8;
  logic       e8;
  logic [1:0] m8;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  setfirst_mask_unit #(.WIDTH(6), .SCAN_STYLE(1)) u_setfirst_mask_unit (
    .clk(clk), .rst_n(rst_n), .src_mask(s6), .pred_mask(p6), .pred_en(e6),
    .mode(m6), .prev_mask(v6), .dest_mask(d6_tree));

  setfirst_mask_unit #(.WIDTH(6), .SCAN_STYLE(0)) u_setfirst_mask_unit_ser (
    .clk(clk), .rst_n(rst_n), .src_mask(s6), .pred_mask(p6), .pred_en(e6),
    .mode(m6), .prev_mask(v6), .dest_mask(d6_ser));

  setfirst_mask_unit #(.WIDTH(8), .SCAN_STYLE(1)) u_setfirst_mask_unit_w8 (
    .clk(clk), .rst_n(rst_n), .src_mask(s8), .pred_mask(p8), .pred_en(e8),
    .mode(m8), .prev_mask(v8), .dest_mask(d8));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Bit-serial model written from the requirements.
  function automatic logic [7:0] model(input int w, input logic [1:0] m,
      input logic [7:0] s, input logic [7:0] p, input logic pen, input logic [7:0] pv);
    logic [7:0] r;
    logic seeking;
    r = 8'h00;
    seeking = 1'b1;
    for (int i = 0; i < w; i++) begin
      if (m == 2'd3) begin
        r[i] = pv[i];                        // R9
      end else if (pen && !p[i]) begin
        r[i] = pv[i];                        // R8
        seeking = 1'b1;                      // R7: next active run restarts
      end else begin
        case (m)
          2'd0:    r[i] = seeking && !s[i];  // R2, R3
          2'd1:    r[i] = seeking;           // R4
          default: r[i] = seeking && s[i];   // R5
        endcase
        if (s[i]) seeking = 1'b0;
      end
    end
    return r;
  endfunction

  function automatic string tag_of(input logic [1:0] m, input logic pen, input logic [7:0] s);
    string t;
    case (m)
      2'd0:    t = (s == 8'h00) ? "R3" : "R2";
      2'd1:    t = "R4";
      2'd2:    t = "R5";
      default: t = "R9";
    endcase
    return pen ? {t, " R7 R8"} : {t, " R6"};
  endfunction

  task automatic drive8(input logic [1:0] m, input logic [7:0] s, input logic [7:0] p,
                        input logic pen, input logic [7:0] pv);
    m8 = m; s8 = s; p8 = p; e8 = pen; v8 = pv;
  endtask

  task automatic run8(input string tag, input logic [1:0] m, input logic [7:0] s,
                      input logic [7:0] p, input logic pen, input logic [7:0] pv,
                      input logic [7:0] exp);
    drive8(m, s, p, pen, pv);
    @(negedge clk);
    chk(tag, d8, exp);
  endtask

  initial begin
    checks = 0;
    failures = 0;
    rst_n = 1'b1;
    s6 = '0; p6 = '0; v6 = '0; e6 = 1'b0; m6 = 2'd0;
    s8 = '0; p8 = '0; v8 = '0; e8 = 1'b0; m8 = 2'd0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset value
    chk("R1 reset w8", d8, 8'h00);
    chk("R1 reset w6", {2'b00, d6_tree}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // Worked patterns, 8 bits.
    run8("R2 before 10010100",   2'd0, 8'b10010100, 8'h00, 1'b0, 8'h00, 8'b00000011);
    run8("R2 before 10010101",   2'd0, 8'b10010101, 8'h00, 1'b0, 8'hFF, 8'b00000000);
    run8("R3 before empty",      2'd0, 8'h00,       8'h00, 1'b0, 8'h00, 8'hFF);
    run8("R4 include 10010100",  2'd1, 8'b10010100, 8'h00, 1'b0, 8'h00, 8'b00000111);
    run8("R5 only 10010100",     2'd2, 8'b10010100, 8'h00, 1'b0, 8'hFF, 8'b00000100);
    run8("R5 only empty",        2'd2, 8'h00,       8'h00, 1'b0, 8'h5A, 8'h00);
    run8("R6 predicate ignored", 2'd0, 8'b00010000, 8'h00, 1'b0, 8'hAA, 8'b00001111);
    run8("R7 before 11000011",   2'd0, 8'b10010100, 8'b11000011, 1'b1, 8'h00, 8'b01000011);
    run8("R7 only 11000011",     2'd2, 8'b11010100, 8'b11000011, 1'b1, 8'h00, 8'b01000000);
    run8("R7 bit0 masked",       2'd0, 8'h00,       8'b11111110, 1'b1, 8'h00, 8'b11111110);
    run8("R8 masked keep prev",  2'd2, 8'b11010100, 8'b11000011, 1'b1, 8'h3C, 8'b01111100);
    run8("R9 hold prev",         2'd3, 8'b10010100, 8'h0F,       1'b1, 8'hA5, 8'hA5);

    // R1: one-cycle latency; result unchanged before the next edge.
    drive8(2'd1, 8'b00001000, 8'h00, 1'b0, 8'h00);
    #1 chk("R1 no early update", d8, 8'hA5);
    @(negedge clk);
    chk("R1 update after edge", d8, 8'b00001111);

    // Exhaustive 6-bit sweep: all sources, predicates, enables and modes.
    for (int idx = 0; idx < 32768; idx++) begin
      logic [14:0] iv;
      logic [5:0]  pv;
      iv = idx[14:0];
      pv = 6'((idx * 37) ^ (idx >> 5));
      m6 = iv[1:0]; e6 = iv[2]; s6 = iv[8:3]; p6 = iv[14:9]; v6 = pv;
      @(negedge clk);
      begin
        logic [7:0] exp;
        exp = model(6, iv[1:0], {2'b00, iv[8:3]}, {2'b00, iv[14:9]}, iv[2], {2'b00, pv});
        chk(tag_of(iv[1:0], iv[2], {2'b00, iv[8:3]}), {2'b00, d6_tree}, exp);
        chk("R10 serial matches tree", {2'b00, d6_ser}, {2'b00, d6_tree});
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule